// File: doc/BRIEF.md
# Measurement Conversion Mode Sequencer

This block decides when a single shared converter measures the battery voltage and when it measures the die temperature. A host writes a 2-bit mode field. The block then either stays asleep, runs one voltage conversion, runs one temperature conversion, or scans in a loop. In the loop it converts voltage, then temperature, and then waits out an idle gap before the next round. After a single conversion finishes, the block writes the mode field back to sleep by itself.

The converter is abstract. The block pulses `conv_start` with a select bit and then waits for `conv_done`, which arrives together with a right-justified code. The converter sets the conversion time, which is about 10 ms in the target system. The idle gap of the automatic scan is counted in strobes of an external timebase (`tick`). A bench can therefore use a few ticks, while a chip would use a gap of about two seconds.

Each result is stored left-justified in a 16-bit register. The upper byte of the new result is compared against a high and a low byte threshold for its own quantity, which gives two flags per quantity.

Top module: `meas_sched`

## Requirements
- R1: After reset, all of the following hold:
  - `mode_q` is 00, both results are 0000h and all four flags are 0, and `conv_start` stays low.
  - The high thresholds reset to FFh and the low thresholds reset to 00h. As a result, a voltage code of 3FFFh or 0000h raises no flag.
- R2: Mode 10 requests one voltage conversion. `mode_q` takes the written value one cycle after the `mode_wr` edge. On the next edge, `conv_start` pulses for one cycle with `conv_sel`=0.
- R3: Mode 01 requests one temperature conversion. It is issued with the same timing as R2, but with `conv_sel`=1.
- R4: When a single-shot conversion's `conv_done` is accepted, `mode_q` reads 00 from the next cycle on and no further start is issued. This clearing happens only if the mode field still holds the value that launched the conversion.
- R5: Mode 11 is the automatic scan, which runs as follows:
  - A voltage conversion starts first.
  - On the same edge that accepts the voltage `conv_done`, a temperature start (`conv_sel`=1) is issued.
  - After the temperature completes, no start is issued until IDLE_TICKS `tick` strobes have been seen.
  - One cycle after the last of those strobes, a voltage conversion starts again.
- R6: A mode write while a conversion is in flight issues no start until that conversion's `conv_done`. The newly written mode then begins one cycle after the done edge.
- R7: The voltage result is the 14-bit code shifted into bits 15:2, with bits 1:0 zero. For example, code 2C07h gives B01Ch.
- R8: The temperature result uses only code bits 9:0, shifted into bits 15:6, with bits 5:0 zero. For example, code 3E00h gives 8000h.
- R9: A result register changes only on the edge that accepts `conv_done` for its own quantity. A `conv_done` that arrives while no conversion is in flight leaves both results unchanged.
- R10: A quantity's flags are updated each time a conversion of that quantity completes. The high flag is set when result[15:8] is greater than the high threshold. The low flag is set when result[15:8] is less than the low threshold. Equality sets neither flag.
- R11: `thr_wr` writes `thr_wdata` into the threshold that `thr_sel` names: 00 is voltage high, 01 is voltage low, 10 is temperature high and 11 is temperature low.
- R12: Mode 00 issues no starts. If mode 00 is written during an automatic scan, the scan stops after the conversion in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe for the automatic idle gap |
| mode_wr | input | 1 | Host write strobe for the mode field |
| mode_wdata | input | 2 | Mode value to write |
| mode_q | output | 2 | Current mode field |
| thr_wr | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold select (see R11) |
| thr_wdata | input | 8 | Threshold value |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_sel | output | 1 | 0 selects voltage, 1 selects temperature |
| conv_done | input | 1 | Converter completion strobe |
| conv_code | input | 14 | Right-justified converter code, valid with `conv_done` |
| volt_res | output | 16 | Left-justified voltage result |
| temp_res | output | 16 | Left-justified temperature result |
| volt_hi_flag | output | 1 | Voltage above high threshold |
| volt_lo_flag | output | 1 | Voltage below low threshold |
| temp_hi_flag | output | 1 | Temperature above high threshold |
| temp_lo_flag | output | 1 | Temperature below low threshold |

## Verification
- A mode write shows on `mode_q` one cycle after its edge, and the resulting start pulse shows one cycle after that. The bench therefore checks `conv_start` at exactly the second falling edge after the write.
- Results, flags and the self-clear of the mode all appear on the single edge that accepts `conv_done`. They are checked at the falling edge right after that strobe. The automatic temperature start is checked at the same falling edge.
- Around the idle gap, the absence of a start is checked at each falling edge after every tick. The restart is then expected exactly one falling edge after the final tick is taken.

// File: rtl/meas_pkg.sv
package meas_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_TEMP  = 2'b01,
    MODE_VOLT  = 2'b10,
    MODE_AUTO  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_GAP  = 2'b10
  } seq_st_e;

  localparam logic SEL_VOLT = 1'b0;
  localparam logic SEL_TEMP = 1'b1;

endpackage

// File: rtl/meas_mode_seq.sv
module meas_mode_seq
  import meas_pkg::*;
#(
  parameter int IDLE_TICKS = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       conv_done,
  output logic [1:0] mode_q,
  output logic       conv_start,
  output logic       conv_sel,
  output logic       cap_volt,
  output logic       cap_temp
);

  localparam int GAP_W = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(IDLE_TICKS - 1);

  seq_st_e          state;
  logic [1:0]       run_mode;
  logic [GAP_W-1:0] gap_cnt;
  logic             accept;

  // A converter cannot finish in the cycle it is started.
  always_comb begin
    accept   = (state == ST_BUSY) && conv_done && !conv_start;
    cap_volt = accept && (conv_sel == SEL_VOLT);
    cap_temp = accept && (conv_sel == SEL_TEMP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_SLEEP;
      state      <= ST_IDLE;
      run_mode   <= MODE_SLEEP;
      conv_start <= 1'b0;
      conv_sel   <= SEL_VOLT;
      gap_cnt    <= '0;
    end else begin
      conv_start <= 1'b0;
      if (mode_wr) mode_q <= mode_wdata;

      case (state)
        ST_IDLE: begin
          if (mode_q != MODE_SLEEP) begin
            conv_start <= 1'b1;
            conv_sel   <= (mode_q == MODE_TEMP) ? SEL_TEMP : SEL_VOLT;
            run_mode   <= mode_q;
            state      <= ST_BUSY;
          end
        end

        ST_BUSY: begin
          if (accept) begin
            if (run_mode == MODE_AUTO && mode_q == MODE_AUTO && conv_sel == SEL_VOLT) begin
              conv_start <= 1'b1;
              conv_sel   <= SEL_TEMP;
            end else if (run_mode == MODE_AUTO && mode_q == MODE_AUTO) begin
              state   <= ST_GAP;
              gap_cnt <= '0;
            end else begin
              state <= ST_IDLE;
              if (run_mode != MODE_AUTO && mode_q == run_mode && !mode_wr)
                mode_q <= MODE_SLEEP;
            end
          end
        end

        ST_GAP: begin
          if (mode_q != MODE_AUTO) begin
            state <= ST_IDLE;
          end else if (tick) begin
            if (gap_cnt == GAP_LAST) state <= ST_IDLE;
            else                     gap_cnt <= gap_cnt + 1'b1;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/meas_channel.sv
module meas_channel #(
  parameter int          RES_W     = 16,
  parameter int          CODE_BITS = 14,
  parameter int          THR_W     = 8,
  parameter logic [7:0]  HI_RST    = 8'hFF,
  parameter logic [7:0]  LO_RST    = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic [CODE_BITS-1:0] code,
  input  logic                 wr_hi,
  input  logic                 wr_lo,
  input  logic [THR_W-1:0]     wdata,
  output logic [RES_W-1:0]     result,
  output logic                 hi_flag,
  output logic                 lo_flag
);

  localparam int PAD = RES_W - CODE_BITS;

  logic [THR_W-1:0] thr_hi;
  logic [THR_W-1:0] thr_lo;
  logic [RES_W-1:0] aligned;
  logic [THR_W-1:0] top_byte;

  always_comb begin
    aligned  = {code, {PAD{1'b0}}};
    top_byte = aligned[RES_W-1 -: THR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_hi  <= THR_W'(HI_RST);
      thr_lo  <= THR_W'(LO_RST);
      result  <= '0;
      hi_flag <= 1'b0;
      lo_flag <= 1'b0;
    end else begin
      if (wr_hi) thr_hi <= wdata;
      if (wr_lo) thr_lo <= wdata;
      if (cap) begin
        result  <= aligned;
        hi_flag <= (top_byte > thr_hi);
        lo_flag <= (top_byte < thr_lo);
      end
    end
  end

endmodule

// File: rtl/meas_sched.sv
module meas_sched #(
  parameter int RES_W      = 16,
  parameter int CODE_W     = 14,
  parameter int VOLT_BITS  = 14,
  parameter int TEMP_BITS  = 10,
  parameter int THR_W      = 8,
  parameter int IDLE_TICKS = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  output logic [1:0]        mode_q,
  input  logic              thr_wr,
  input  logic [1:0]        thr_sel,
  input  logic [THR_W-1:0]  thr_wdata,
  output logic              conv_start,
  output logic              conv_sel,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  output logic [RES_W-1:0]  volt_res,
  output logic [RES_W-1:0]  temp_res,
  output logic              volt_hi_flag,
  output logic              volt_lo_flag,
  output logic              temp_hi_flag,
  output logic              temp_lo_flag
);

  localparam int NCH = 2;

  logic             cap_volt;
  logic             cap_temp;
  logic [NCH-1:0]   cap_arr;
  logic [RES_W-1:0] res_arr [NCH];
  logic [NCH-1:0]   hi_arr;
  logic [NCH-1:0]   lo_arr;

  meas_mode_seq #(.IDLE_TICKS(IDLE_TICKS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .conv_done  (conv_done),
    .mode_q     (mode_q),
    .conv_start (conv_start),
    .conv_sel   (conv_sel),
    .cap_volt   (cap_volt),
    .cap_temp   (cap_temp)
  );

  assign cap_arr = {cap_temp, cap_volt};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int CB = (g == 0) ? VOLT_BITS : TEMP_BITS;
    logic wr_hi;
    logic wr_lo;
    assign wr_hi = thr_wr && (thr_sel[1] == 1'(g)) && !thr_sel[0];
    assign wr_lo = thr_wr && (thr_sel[1] == 1'(g)) &&  thr_sel[0];

    meas_channel #(
      .RES_W     (RES_W),
      .CODE_BITS (CB),
      .THR_W     (THR_W)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .cap     (cap_arr[g]),
      .code    (conv_code[CB-1:0]),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wdata   (thr_wdata),
      .result  (res_arr[g]),
      .hi_flag (hi_arr[g]),
      .lo_flag (lo_arr[g])
    );
  end

  assign volt_res     = res_arr[0];
  assign temp_res     = res_arr[1];
  assign volt_hi_flag = hi_arr[0];
  assign volt_lo_flag = lo_arr[0];
  assign temp_hi_flag = hi_arr[1];
  assign temp_lo_flag = lo_arr[1];

endmodule

// File: rtl/meas_sched_chk.sv
module meas_sched_chk #(
  parameter int RES_W     = 16,
  parameter int VOLT_BITS = 14,
  parameter int TEMP_BITS = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_wr,
  input logic             conv_done,
  input logic             conv_start,
  input logic [1:0]       mode_q,
  input logic             cap_volt,
  input logic             cap_temp,
  input logic [RES_W-1:0] volt_res,
  input logic [RES_W-1:0] temp_res
);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  p_clear_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00 && $past(mode_q) != 2'b00) |-> ($past(mode_wr) || $past(conv_done)));

  p_volt_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    volt_res[RES_W-VOLT_BITS-1:0] == '0);

  p_temp_low_zero_r8: assert property (@(posedge clk) disable iff (rst)
    temp_res[RES_W-TEMP_BITS-1:0] == '0);

  p_volt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cap_volt |=> $stable(volt_res));

  p_temp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cap_temp |=> $stable(temp_res));

  p_cap_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
    (cap_volt || cap_temp) |-> (conv_done && !(cap_volt && cap_temp)));

  p_no_start_asleep_r12: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(mode_q) != 2'b00);

endmodule

bind meas_sched meas_sched_chk #(
  .RES_W     (RES_W),
  .VOLT_BITS (VOLT_BITS),
  .TEMP_BITS (TEMP_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_wr    (mode_wr),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .mode_q     (mode_q),
  .cap_volt   (cap_volt),
  .cap_temp   (cap_temp),
  .volt_res   (volt_res),
  .temp_res   (temp_res)
);

// File: tb/meas_sched_test.sv
module meas_sched_test;

  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = 2'b00;
  logic [1:0]  mode_q;
  logic        thr_wr = 1'b0;
  logic [1:0]  thr_sel = 2'b00;
  logic [7:0]  thr_wdata = 8'h00;
  logic        conv_start;
  logic        conv_sel;
  logic        conv_done = 1'b0;
  logic [13:0] conv_code = '0;
  logic [15:0] volt_res;
  logic [15:0] temp_res;
  logic        volt_hi_flag, volt_lo_flag, temp_hi_flag, temp_lo_flag;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  meas_sched #(.IDLE_TICKS(GAP)) uut (
    .clk(clk), .rst(rst), .tick(tick),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_q(mode_q),
    .thr_wr(thr_wr), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
    .conv_start(conv_start), .conv_sel(conv_sel),
    .conv_done(conv_done), .conv_code(conv_code),
    .volt_res(volt_res), .temp_res(temp_res),
    .volt_hi_flag(volt_hi_flag), .volt_lo_flag(volt_lo_flag),
    .temp_hi_flag(temp_hi_flag), .temp_lo_flag(temp_lo_flag)
  );

  typedef struct packed {
    logic        ch;
    logic [13:0] code;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] res;
    logic        ehi;
    logic        elo;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 14'h3FFF, 8'hFF, 8'h00, 16'hFFFC, 1'b0, 1'b0},
    '{1'b0, 14'h2000, 8'h7F, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{1'b0, 14'h1FFF, 8'h7F, 8'h80, 16'h7FFC, 1'b0, 1'b1},
    '{1'b0, 14'h2C07, 8'hB0, 8'h10, 16'hB01C, 1'b0, 1'b0},
    '{1'b0, 14'h0000, 8'hFF, 8'h01, 16'h0000, 1'b0, 1'b1},
    '{1'b1, 14'h03FF, 8'hFF, 8'h00, 16'hFFC0, 1'b0, 1'b0},
    '{1'b1, 14'h0200, 8'h7F, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{1'b1, 14'h01FF, 8'h80, 8'h80, 16'h7FC0, 1'b0, 1'b1},
    '{1'b1, 14'h3E00, 8'h8E, 8'h20, 16'h8000, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic write_thr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); thr_wr = 1'b1; thr_sel = s; thr_wdata = d;
    @(negedge clk); thr_wr = 1'b0;
  endtask

  task automatic drive_done(input logic [13:0] c);
    conv_done = 1'b1; conv_code = c;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(mode_q == 2'b00, "R1 mode", mode_q, 0);
    chk(volt_res == 0 && temp_res == 0, "R1 results", {volt_res, temp_res}, 0);
    chk({volt_hi_flag, volt_lo_flag, temp_hi_flag, temp_lo_flag} == 4'b0, "R1 flags",
        {volt_hi_flag, volt_lo_flag, temp_hi_flag, temp_lo_flag}, 0);
    chk(conv_start == 1'b0, "R1 start", conv_start, 0);

    // R7 R8 R10 R11 R2 R3 R4: table walk
    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      write_thr({v.ch, 1'b0}, v.hi);
      write_thr({v.ch, 1'b1}, v.lo);
      write_mode(v.ch ? 2'b01 : 2'b10);
      @(negedge clk);
      chk(conv_start == 1'b1 && conv_sel == v.ch, v.ch ? "R3 start" : "R2 start",
          {conv_start, conv_sel}, {1'b1, v.ch});
      @(negedge clk);
      chk(conv_start == 1'b0, "R2 one-cycle start", conv_start, 0);
      drive_done(v.code);
      if (v.ch) begin
        chk(temp_res == v.res, "R8 temp result", temp_res, v.res);
        chk({temp_hi_flag, temp_lo_flag} == {v.ehi, v.elo}, "R10 temp flags",
            {temp_hi_flag, temp_lo_flag}, {v.ehi, v.elo});
      end else begin
        chk(volt_res == v.res, "R7 volt result", volt_res, v.res);
        chk({volt_hi_flag, volt_lo_flag} == {v.ehi, v.elo}, "R10 volt flags",
            {volt_hi_flag, volt_lo_flag}, {v.ehi, v.elo});
      end
      chk(mode_q == 2'b00, "R4 self-clear", mode_q, 0);
      @(negedge clk);
      chk(conv_start == 1'b0, "R4 no restart", conv_start, 0);
    end

    // R9: stray done while idle
    drive_done(14'h0123);
    chk(volt_res == 16'h8000 - 16'h8000 + 16'h0000 && temp_res == 16'h8000, "R9 stray done",
        {volt_res, temp_res}, {16'h0000, 16'h8000});

    // R5: automatic scan
    write_mode(2'b11);
    @(negedge clk);
    chk(conv_start && conv_sel == 1'b0, "R5 auto volt start", {conv_start, conv_sel}, 2'b10);
    @(negedge clk);
    drive_done(14'h1000);
    chk(volt_res == 16'h4000, "R5 auto volt result", volt_res, 16'h4000);
    chk(conv_start && conv_sel == 1'b1, "R5 auto temp start", {conv_start, conv_sel}, 2'b11);
    @(negedge clk);
    drive_done(14'h0100);
    chk(temp_res == 16'h4000, "R5 auto temp result", temp_res, 16'h4000);
    for (int k = 0; k < GAP; k++) begin
      pulse_tick();
      chk(conv_start == 1'b0, "R5 gap quiet", conv_start, 0);
    end
    @(negedge clk);
    chk(conv_start && conv_sel == 1'b0, "R5 rescan", {conv_start, conv_sel}, 2'b10);

    // R12: sleep written mid-conversion stops the scan
    write_mode(2'b00);
    drive_done(14'h0400);
    chk(volt_res == 16'h1000, "R12 finish in flight", volt_res, 16'h1000);
    for (int k = 0; k < 6; k++) begin
      if (k == 2) pulse_tick(); else @(negedge clk);
      chk(conv_start == 1'b0, "R12 no start asleep", conv_start, 0);
    end

    // R6: mode change during a conversion
    write_mode(2'b10);
    @(negedge clk);
    chk(conv_start && conv_sel == 1'b0, "R6 first start", {conv_start, conv_sel}, 2'b10);
    write_mode(2'b01);
    @(negedge clk);
    chk(conv_start == 1'b0, "R6 waits", conv_start, 0);
    drive_done(14'h0004);
    chk(volt_res == 16'h0010 && mode_q == 2'b01, "R6 completes, no clear",
        {volt_res, 14'h0, mode_q}, {16'h0010, 14'h0, 2'b01});
    chk(conv_start == 1'b0, "R6 gap cycle", conv_start, 0);
    @(negedge clk);
    chk(conv_start && conv_sel == 1'b1, "R6 new mode", {conv_start, conv_sel}, 2'b11);
    @(negedge clk);
    drive_done(14'h0040);
    chk(temp_res == 16'h1000 && mode_q == 2'b00, "R6 then R4 clear",
        {temp_res, 14'h0, mode_q}, {16'h1000, 16'h0});

    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule